// File: doc/BRIEF.md
# Masked Vector Pick-Reduction Unit

This block takes a vector of `LANES` elements, each `ELEM_W` bits wide, and a selection mask with one bit per lane. It returns, as one scalar, the element whose mask bit is set. Each lane carries a None flag beside its data. A lane that is not selected becomes None and its data is forced to zero. The result port carries a None flag of its own, so an empty selection is reported rather than hidden.

Two datapaths are built side by side, and the per-input `mode_sel` bit chooses one of them.

- **Tree mode (`mode_sel` = 0):** a pairwise reduction runs over `log2(LANES)` registered stages. At every node the lower-numbered operand is kept unless it is None, so the surviving value ends up in lane 0.
- **Direct mode (`mode_sel` = 1):** the lanes before the first set mask bit are counted, starting from lane 0. That count becomes the lane-0 entry of an index vector, and an index-driven lane select fetches the element in one registered cycle.

The stream interface has a valid strobe and no ready.

- Every cycle with `in_valid` high is accepted.
- The block never applies back-pressure.
- The consumer must take the result in the one cycle that `out_valid` is high.
- If a tree result and a direct result would both leave the block in the same cycle, the tree result is delivered and the direct result is discarded.

Top module: `masked_pick_reduce`

## Requirements
- R1: In tree mode (`mode_sel`=0), a mask with only bit k set (bit i belongs to lane i, which is `data_in[i]`) gives `result` = `data_in[k]` and `result_none` = 0.
- R2: In tree mode, `out_valid` rises exactly log2(LANES) cycles after the cycle in which `in_valid` was high, and stays low in the cycles between.
- R3: In direct mode (`mode_sel`=1), the index is the number of clear mask bits below the lowest set bit, counted from lane 0. `result` = `data_in[index]` with `out_valid` high exactly one cycle after the input.
- R4: An all-zero mask gives `result_none` = 1 and `result` = 0 in both modes.
- R5: When several mask bits are set, the lowest-numbered selected lane is returned in both modes.
- R6: For the same data and mask, both modes deliver the same `result` and `result_none`.
- R7: While `out_valid` is low, `result` is 0 and `result_none` is 1.
- R8: When a tree result and a direct result complete in the same cycle, the tree result is output and the direct result is dropped. No second `out_valid` pulse follows for it.
- R9: During and right after reset `out_valid` is 0. An input accepted just before reset produces no output.
- R10: Inputs presented on consecutive cycles are all accepted, and their results come out in order, one per cycle, with no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector and mask are present this cycle |
| mode_sel | input | 1 | 0 = reduction tree, 1 = direct index select |
| data_in | input | LANES*ELEM_W | Data lanes, lane i in `data_in[i]` |
| mask_in | input | LANES | Selection mask, bit i selects lane i |
| out_valid | output | 1 | Result is present this cycle |
| result | output | ELEM_W | Selected element, zero when None |
| result_none | output | 1 | Result is None (empty selection or idle) |

## Verification
Every single-bit mask is run in both modes with distinct lane values. This shows that each tree node and each decoded index reaches the right lane, and a swapped pairing shows up as a wrong value.

- **All-zero mask:** tells a None result apart from a legitimate zero in data.
- **Multi-hot masks:** patterns chosen so the lowest set bit sits in different tree subtrees expose any priority that prefers a higher lane.
- **Random patterns run in both modes:** show whether the two paths agree with each other.
- **Timed tests:**
  - a back-to-back burst shows in-order streaming;
  - an overlapped tree/direct pair shows the collision rule;
  - a reset in flight shows that pending work is cleared.

// File: rtl/pick_pkg.sv
package pick_pkg;

  typedef enum logic {
    MODE_TREE   = 1'b0,
    MODE_DIRECT = 1'b1
  } pick_mode_e;

  function automatic bit is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/pr_masked_pick.sv
module pr_masked_pick #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic [LANES-1:0][W-1:0] data_in,
  input  logic [LANES-1:0]        mask_in,
  output logic [LANES-1:0][W-1:0] lane_d,
  output logic [LANES-1:0]        lane_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i] = ~mask_in[i];
    assign lane_d[i] = mask_in[i] ? data_in[i] : '0;
  end
endmodule

// File: rtl/pr_combine.sv
module pr_combine #(
  parameter int IN_L = 8,
  parameter int W    = 16,
  localparam int OUT_L = IN_L / 2
) (
  input  logic [IN_L-1:0][W-1:0]  d_in,
  input  logic [IN_L-1:0]         n_in,
  output logic [OUT_L-1:0][W-1:0] d_out,
  output logic [OUT_L-1:0]        n_out
);
  // lower lane of each pair has priority unless it is None
  for (genvar j = 0; j < OUT_L; j++) begin : g_pair
    assign d_out[j] = n_in[2*j] ? d_in[2*j+1] : d_in[2*j];
    assign n_out[j] = n_in[2*j] & n_in[2*j+1];
  end
endmodule

// File: rtl/pr_tree.sv
module pr_tree #(
  parameter int LANES = 8,
  parameter int W     = 16,
  localparam int STAGES = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES-1:0][W-1:0] d_in,
  input  logic [LANES-1:0]        n_in,
  output logic                    out_valid,
  output logic [W-1:0]            d_out,
  output logic                    n_out
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    localparam int IN_L  = LANES >> s;
    localparam int OUT_L = IN_L / 2;

    logic [IN_L-1:0][W-1:0]  src_d;
    logic [IN_L-1:0]         src_n;
    logic                    src_v;
    logic [OUT_L-1:0][W-1:0] cmb_d;
    logic [OUT_L-1:0]        cmb_n;
    logic [OUT_L-1:0][W-1:0] q_d;
    logic [OUT_L-1:0]        q_n;
    logic                    q_v;

    if (s == 0) begin : g_first
      assign src_d = d_in;
      assign src_n = n_in;
      assign src_v = in_valid;
    end else begin : g_next
      assign src_d = g_st[s-1].q_d;
      assign src_n = g_st[s-1].q_n;
      assign src_v = g_st[s-1].q_v;
    end

    pr_combine #(.IN_L(IN_L), .W(W)) u_comb (
      .d_in (src_d),
      .n_in (src_n),
      .d_out(cmb_d),
      .n_out(cmb_n)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_v <= 1'b0;
        q_d <= '0;
        q_n <= '1;
      end else begin
        q_v <= src_v;
        q_d <= cmb_d;
        q_n <= cmb_n;
      end
    end
  end

  assign out_valid = g_st[STAGES-1].q_v;
  assign d_out     = g_st[STAGES-1].q_d[0];
  assign n_out     = g_st[STAGES-1].q_n[0];
endmodule

// File: rtl/pr_lzc.sv
module pr_lzc #(
  parameter int LANES = 8,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] mask,
  output logic [IDX_W-1:0] idx,
  output logic             none
);
  // zero lanes ahead of the first set lane, lane 0 counted first
  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx  = IDX_W'(i);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pr_shuffle.sv
module pr_shuffle #(
  parameter int LANES = 8,
  parameter int W     = 16,
  parameter int OUT_L = 1,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][W-1:0]     data,
  input  logic [OUT_L-1:0][IDX_W-1:0] sel_idx,
  input  logic [OUT_L-1:0]            sel_none,
  output logic [OUT_L-1:0][W-1:0]     out_d,
  output logic [OUT_L-1:0]            out_n
);
  // each output lane reads the lane its index names; repeats are legal
  for (genvar o = 0; o < OUT_L; o++) begin : g_out
    assign out_n[o] = sel_none[o];
    assign out_d[o] = sel_none[o] ? '0 : data[sel_idx[o]];
  end
endmodule

// File: rtl/masked_pick_reduce.sv
module masked_pick_reduce #(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         mode_sel,
  input  logic [LANES-1:0][ELEM_W-1:0] data_in,
  input  logic [LANES-1:0]             mask_in,
  output logic                         out_valid,
  output logic [ELEM_W-1:0]            result,
  output logic                         result_none
);
  import pick_pkg::*;

  localparam int IDX_W = $clog2(LANES);

  initial begin
    if (!is_pow2(LANES)) $error("LANES must be a power of two, at least 2");
  end

  // tree path
  logic [LANES-1:0][ELEM_W-1:0] pk_d;
  logic [LANES-1:0]             pk_n;
  logic                         tree_in_v;
  logic                         tree_v;
  logic [ELEM_W-1:0]            tree_d;
  logic                         tree_n;

  pr_masked_pick #(.LANES(LANES), .W(ELEM_W)) u_pick (
    .data_in(data_in),
    .mask_in(mask_in),
    .lane_d (pk_d),
    .lane_n (pk_n)
  );

  assign tree_in_v = in_valid & (mode_sel == MODE_TREE);

  pr_tree #(.LANES(LANES), .W(ELEM_W)) u_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (tree_in_v),
    .d_in     (pk_d),
    .n_in     (pk_n),
    .out_valid(tree_v),
    .d_out    (tree_d),
    .n_out    (tree_n)
  );

  // direct path
  logic [IDX_W-1:0]            lz_idx;
  logic                        lz_none;
  logic [0:0][IDX_W-1:0]       iv_idx;
  logic [0:0]                  iv_none;
  logic [0:0][ELEM_W-1:0]      sh_d;
  logic [0:0]                  sh_n;
  logic                        dir_v;
  logic [ELEM_W-1:0]           dir_d;
  logic                        dir_n;

  pr_lzc #(.LANES(LANES)) u_lzc (
    .mask(mask_in),
    .idx (lz_idx),
    .none(lz_none)
  );

  assign iv_idx[0]  = lz_idx;
  assign iv_none[0] = lz_none;

  pr_shuffle #(.LANES(LANES), .W(ELEM_W), .OUT_L(1)) u_shuf (
    .data    (data_in),
    .sel_idx (iv_idx),
    .sel_none(iv_none),
    .out_d   (sh_d),
    .out_n   (sh_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_v <= 1'b0;
      dir_d <= '0;
      dir_n <= 1'b1;
    end else begin
      dir_v <= in_valid & (mode_sel == MODE_DIRECT);
      dir_d <= sh_d[0];
      dir_n <= sh_n[0];
    end
  end

  // output merge: tree has priority on a collision
  always_comb begin
    out_valid   = 1'b0;
    result      = '0;
    result_none = 1'b1;
    if (tree_v) begin
      out_valid   = 1'b1;
      result      = tree_d;
      result_none = tree_n;
    end else if (dir_v) begin
      out_valid   = 1'b1;
      result      = dir_d;
      result_none = dir_n;
    end
  end
endmodule

// File: rtl/pr_checker.sv
module pr_checker #(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              mode_sel,
  input logic [LANES-1:0]  mask_in,
  input logic              out_valid,
  input logic [ELEM_W-1:0] result,
  input logic              result_none,
  input logic              tree_done
);
  AST_IDLE_IS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (result_none && result == '0)); // R7

  AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid && mode_sel)) |-> out_valid); // R3

  AST_DIRECT_EMPTY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid && mode_sel && mask_in == '0) && !tree_done)
      |-> result_none); // R4

  AST_DIRECT_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid && mode_sel && mask_in != '0) && !tree_done)
      |-> !result_none); // R3

  AST_TREE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tree_done |-> out_valid); // R8
endmodule

bind masked_pick_reduce pr_checker #(.LANES(LANES), .ELEM_W(ELEM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .mode_sel   (mode_sel),
  .mask_in    (mask_in),
  .out_valid  (out_valid),
  .result     (result),
  .result_none(result_none),
  .tree_done  (tree_v)
);

// File: tb/masked_pick_reduce_tb.sv
`timescale 1ns/1ps
module masked_pick_reduce_tb;
  localparam int LANES  = 8;
  localparam int ELEM_W = 16;
  localparam int STAGES = $clog2(LANES);
  localparam int NTAB   = 15;

  // entry: {mask[11:4], expect_none[3], expect_lane[2:0]}
  localparam logic [11:0] TABLE [NTAB] = '{
    12'h010, 12'h021, 12'h042, 12'h083, 12'h104, 12'h205, 12'h406, 12'h807,
    12'h008, 12'h0C2, 12'hFF0, 12'h810, 12'hA05, 12'h061, 12'hC06
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic mode_sel = 1'b0;
  logic [LANES-1:0][ELEM_W-1:0] data_in = '0;
  logic [LANES-1:0] mask_in = '0;
  logic out_valid;
  logic [ELEM_W-1:0] result;
  logic result_none;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  masked_pick_reduce #(.LANES(LANES), .ELEM_W(ELEM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
    .data_in(data_in), .mask_in(mask_in),
    .out_valid(out_valid), .result(result), .result_none(result_none)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [LANES-1:0][ELEM_W-1:0] make_vec(input int seed);
    logic [LANES-1:0][ELEM_W-1:0] v;
    for (int l = 0; l < LANES; l++)
      v[l] = ELEM_W'(16'h5A00 ^ (seed << 4) ^ (l * 16'h0111) ^ 16'h0001);
    return v;
  endfunction

  function automatic int ref_lane(input logic [LANES-1:0] m);
    for (int l = 0; l < LANES; l++) if (m[l]) return l;
    return -1;
  endfunction

  // drive one input, confirm nothing early, sample at the latency
  task automatic run_one(input string req, input logic mode,
                         input logic [LANES-1:0] m,
                         input logic [LANES-1:0][ELEM_W-1:0] v,
                         input logic exp_none, input logic [ELEM_W-1:0] exp_val,
                         output logic [ELEM_W-1:0] got_val, output logic got_none);
    int lat;
    lat = mode ? 1 : STAGES;
    @(negedge clk);
    in_valid = 1'b1; mode_sel = mode; mask_in = m; data_in = v;
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 1; c < lat; c++) begin
      chk("R2", "out_valid before latency", 32'(out_valid), 32'd0);
      @(negedge clk);
    end
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "result_none", 32'(result_none), 32'(exp_none));
    chk(req, "result", 32'(result), 32'(exp_none ? '0 : exp_val));
    got_val = result;
    got_none = result_none;
  endtask

  initial begin
    #(20.0 * 200000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [ELEM_W-1:0] gv, gv2;
    logic gn, gn2;
    logic [LANES-1:0][ELEM_W-1:0] v;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R7", "result_none idle", 32'(result_none), 32'd1);
    chk("R7", "result idle", 32'(result), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "out_valid after reset", 32'(out_valid), 32'd0);

    // table walk, both modes
    for (int e = 0; e < NTAB; e++) begin
      logic [LANES-1:0] m;
      logic en;
      int ln;
      string rq;
      m  = TABLE[e][11:4];
      en = TABLE[e][3];
      ln = int'(TABLE[e][2:0]);
      v  = make_vec(e);
      for (int md = 0; md < 2; md++) begin
        if (en) rq = "R4";
        else if ($countones(m) > 1) rq = "R5";
        else rq = (md == 1) ? "R3" : "R1";
        run_one(rq, md[0], m, v, en, v[ln], gv, gn);
      end
    end

    // R6: random data and masks, both modes vs model and each other
    for (int k = 0; k < 40; k++) begin
      logic [LANES-1:0] m;
      int rl;
      for (int l = 0; l < LANES; l++) v[l] = ELEM_W'($urandom);
      m  = (k % 7 == 0) ? '0 : LANES'($urandom);
      rl = ref_lane(m);
      run_one("R6", 1'b0, m, v, rl < 0, (rl < 0) ? '0 : v[rl], gv, gn);
      run_one("R6", 1'b1, m, v, rl < 0, (rl < 0) ? '0 : v[rl], gv2, gn2);
      chk("R6", "modes agree value", 32'(gv), 32'(gv2));
      chk("R6", "modes agree none", 32'(gn), 32'(gn2));
    end

    // R10: back-to-back tree stream
    @(negedge clk);
    for (int c = 0; c < 8 + STAGES; c++) begin
      if (c >= STAGES) begin
        chk("R10", "stream valid", 32'(out_valid), 32'd1);
        chk("R10", "stream value", 32'(result),
            32'(make_vec(100 + c - STAGES)[(c - STAGES) % LANES]));
      end else begin
        chk("R10", "stream idle head", 32'(out_valid), 32'd0);
      end
      if (c < 8) begin
        in_valid = 1'b1; mode_sel = 1'b0;
        mask_in = LANES'(1) << (c % LANES);
        data_in = make_vec(100 + c);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk("R10", "stream drained", 32'(out_valid), 32'd0);

    // R8: collision, tree issued STAGES-1 cycles before direct
    v = make_vec(200);
    in_valid = 1'b1; mode_sel = 1'b0; mask_in = 8'h08; data_in = v;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (STAGES - 2) @(negedge clk);
    in_valid = 1'b1; mode_sel = 1'b1; mask_in = 8'h40; data_in = make_vec(201);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "collision valid", 32'(out_valid), 32'd1);
    chk("R8", "collision tree value", 32'(result), 32'(v[3]));
    @(negedge clk);
    chk("R8", "direct dropped", 32'(out_valid), 32'd0);

    // R9: reset with work in flight
    in_valid = 1'b1; mode_sel = 1'b0; mask_in = 8'h01; data_in = make_vec(300);
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < STAGES + 1; c++) begin
      chk("R9", "no output after reset", 32'(out_valid), 32'd0);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule